// File: doc/BRIEF.md
# I2C Fan Controller Target

This block is an I2C target that lets a host on a two-wire bus run a cooling fan. The host addresses the target at 7-bit address 0x74. It sends a register pointer byte, then data bytes to write, or it sends a repeated START and reads bytes back. Two writable registers set the fan: a control byte, whose bit 7 turns the fan on, and a duty byte from 0 to 100 percent. The same two pointer values read back the control byte and a measured revolutions-per-second count taken from the fan's tachometer line.

Both bus lines are oversampled by the system clock. Each passes through a two-flop synchronizer and a glitch filter, and the target only ever pulls SDA low. The target state machine has these states: `S_IDLE`, `S_ADDR`, `S_ADDR_ACK`, `S_REG`, `S_REG_ACK`, `S_WDATA`, `S_WDATA_ACK`, `S_RDATA` and `S_RDATA_ACK`. Its transitions are:

- A START from any state goes to `S_ADDR`, and a STOP from any state goes to `S_IDLE`.
- In `S_ADDR`, after eight bits, a matching address goes to `S_ADDR_ACK` and any other address goes to `S_IDLE`.
- `S_ADDR_ACK` goes to `S_REG` for a write or to `S_RDATA` for a read.
- `S_REG` goes to `S_REG_ACK`, which goes to `S_WDATA`.
- `S_WDATA` goes to `S_WDATA_ACK`, which goes back to `S_WDATA`.
- `S_RDATA` goes to `S_RDATA_ACK` after eight bits. From there a host ACK returns to `S_RDATA` and a host NACK goes to `S_IDLE`.

A PWM generator drives the fan. Its period is 100 steps of a prescaled tick. A tachometer counter counts rising edges over a gate window and latches the result once per window.

Top module: `fan_i2c_ctrl`

## Requirements
- R1: The target acknowledges only the address byte 0xE8 (write) or 0xE9 (read), which is address 0x74 plus the R/W bit. Any other address gets no ACK, and the bytes that follow it change nothing.
- R2: The first byte after a write address sets the register pointer. The pointer advances by one after every data byte, whether written or read.
- R3: Writing pointer 0 stores the control byte, whose bit 7 enables the fan. Reading pointer 0 returns the control byte, which is 0x00 after reset.
- R4: While control bit 7 is clear, the PWM output stays low.
- R5: Writing pointer 1 sets the duty. Values above 100 are stored as 100, and the duty is 80 after reset.
- R6: The PWM period is 100 ticks of TICK_DIV clocks each. The output is high for the first N steps of the period, where N is the duty.
- R7: Reading pointer 1 returns the number of tachometer rising edges seen in the last complete window of GATE_CYCLES clocks. The count saturates at 255 and changes only when a window closes.
- R8: Pointers other than 0 and 1 read as 0x00, and writes to them change nothing.
- R9: A repeated START after the pointer byte begins a read at that pointer. A read ends when the host answers a byte with NACK.
- R10: SDA is only pulled low, never driven high. The target changes it only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_pull_low_o | output | 1 | High while the target pulls SDA low (open-drain enable) |
| tach_i | input | 1 | Fan tachometer pulse input, asynchronous |
| pwm_o | output | 1 | Fan PWM drive |

## Verification
The SDA-steadiness property assumes that the host changes SDA only while SCL is low, except when it signals START or STOP. It also assumes the host never issues START or STOP while the target is pulling SDA low. The bench's bus model holds each quarter bit for 20 clocks, well beyond the synchronizer and filter delay. It sets SDA a full quarter period after SCL falls and produces START and STOP only on released lines with SCL high. The duty-range and rate-window properties take no input assumption. The PWM-off property assumes only that the control byte is written through the bus, which the bench always does.

// File: rtl/fan_pkg.sv
package fan_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_REG,
        S_REG_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RDATA_ACK
    } i2c_state_t;

    localparam int PWM_STEPS = 100;
    localparam logic [7:0] DUTY_MAX = 8'd100;
endpackage

// File: rtl/fan_line_filter.sv
module fan_line_filter #(
    parameter int   FILT_LEN = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchronizer, then accept a new level only once it has held for FILT_LEN clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {2{RST_VAL}};
            line_o <= RST_VAL;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                line_o <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fan_i2c_target.sv
module fan_i2c_target
    import fan_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h74
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sda_low
);
    i2c_state_t state;
    logic       scl_d, sda_d, rw_q, m_ack;
    logic [3:0] bit_cnt;
    logic [7:0] shreg, tx;

    wire scl_rise  = scl_f & ~scl_d;
    wire scl_fall  = ~scl_f & scl_d;
    wire start_det = scl_f & scl_d & sda_d & ~sda_f;
    wire stop_det  = scl_f & scl_d & ~sda_d & sda_f;

    // State register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
            rw_q    <= 1'b0;
            m_ack   <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= S_ADDR;
                bit_cnt <= '0;
            end else if (stop_det) begin
                state <= S_IDLE;
            end else begin
                unique case (state)
                    S_IDLE: ;
                    S_ADDR, S_REG, S_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == S_ADDR) begin
                                if (shreg[7:1] == ADDR7) begin
                                    rw_q  <= shreg[0];
                                    state <= S_ADDR_ACK;
                                end else begin
                                    state <= S_IDLE;
                                end
                            end else if (state == S_REG) begin
                                ptr   <= shreg;
                                state <= S_REG_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= shreg;
                                state   <= S_WDATA_ACK;
                            end
                        end
                    end
                    S_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                tx    <= rd_data;
                                state <= S_RDATA;
                            end else begin
                                state <= S_REG;
                            end
                        end
                    end
                    S_REG_ACK: if (scl_fall) state <= S_WDATA;
                    S_WDATA_ACK: begin
                        if (scl_fall) begin
                            ptr   <= ptr + 1'b1;
                            state <= S_WDATA;
                        end
                    end
                    S_RDATA: begin
                        if (scl_fall) begin
                            tx      <= {tx[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == 4'd7) begin
                                bit_cnt <= '0;
                                ptr     <= ptr + 1'b1;
                                state   <= S_RDATA_ACK;
                            end
                        end
                    end
                    S_RDATA_ACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_f;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                tx    <= rd_data;
                                state <= S_RDATA;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Open-drain output decode
    always_comb begin
        unique case (state)
            S_ADDR_ACK, S_REG_ACK, S_WDATA_ACK: sda_low = 1'b1;
            S_RDATA:                            sda_low = ~tx[7];
            default:                            sda_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/fan_pwm.sv
module fan_pwm
    import fan_pkg::*;
#(
    parameter int TICK_DIV = 12_500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] duty,
    output logic       pwm_o
);
    localparam int DW = $clog2(TICK_DIV > 1 ? TICK_DIV : 2);
    localparam int SW = $clog2(PWM_STEPS);

    logic [DW-1:0] div_q;
    logic [SW-1:0] step_q;

    wire tick = (div_q == DW'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            step_q <= '0;
            pwm_o  <= 1'b0;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                step_q <= (step_q == SW'(PWM_STEPS - 1)) ? '0 : step_q + 1'b1;
            end
            pwm_o <= en && (8'(step_q) < duty);
        end
    end
endmodule

// File: rtl/fan_tach.sv
module fan_tach #(
    parameter int GATE_CYCLES = 125_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tach_s,
    output logic [7:0] rps,
    output logic       gate_end
);
    localparam int GW = $clog2(GATE_CYCLES);

    logic          tach_d;
    logic [GW-1:0] gate_q;
    logic [7:0]    edge_q;

    wire rise = tach_s & ~tach_d;
    assign gate_end = (gate_q == GW'(GATE_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tach_d <= 1'b0;
            gate_q <= '0;
            edge_q <= '0;
            rps    <= '0;
        end else begin
            tach_d <= tach_s;
            if (gate_end) begin
                gate_q <= '0;
                rps    <= edge_q;
                edge_q <= rise ? 8'd1 : 8'd0;
            end else begin
                gate_q <= gate_q + 1'b1;
                if (rise && edge_q != 8'hFF) edge_q <= edge_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fan_i2c_ctrl.sv
module fan_i2c_ctrl
    import fan_pkg::*;
#(
    parameter logic [6:0] ADDR7       = 7'h74,
    parameter int         FILT_LEN    = 4,
    parameter int         TICK_DIV    = 12_500,
    parameter int         GATE_CYCLES = 125_000_000,
    parameter logic [7:0] DUTY_RST    = 8'd80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_low_o,
    input  logic tach_i,
    output logic pwm_o
);
    logic       scl_f, sda_f, tach_s;
    logic [7:0] ptr, wr_data, rd_data, ctrl_q, duty_q, rps_q;
    logic       wr_en, fan_en, gate_end;

    fan_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    fan_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));
    fan_line_filter #(.FILT_LEN(1), .RST_VAL(1'b0)) u_tach_sync (
        .clk(clk), .rst_n(rst_n), .line_i(tach_i), .line_o(tach_s));

    fan_i2c_target #(.ADDR7(ADDR7)) u_target (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
        .sda_low(sda_pull_low_o));

    // Register file: pointer 0 control, pointer 1 duty (write) / rate (read)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
            duty_q <= DUTY_RST;
        end else if (wr_en) begin
            if (ptr == 8'd0) ctrl_q <= wr_data;
            else if (ptr == 8'd1) duty_q <= (wr_data > DUTY_MAX) ? DUTY_MAX : wr_data;
        end
    end

    always_comb begin
        unique case (ptr)
            8'd0:    rd_data = ctrl_q;
            8'd1:    rd_data = rps_q;
            default: rd_data = 8'h00;
        endcase
    end

    assign fan_en = ctrl_q[7];

    fan_pwm #(.TICK_DIV(TICK_DIV)) u_pwm (
        .clk(clk), .rst_n(rst_n), .en(fan_en), .duty(duty_q), .pwm_o(pwm_o));

    fan_tach #(.GATE_CYCLES(GATE_CYCLES)) u_tach (
        .clk(clk), .rst_n(rst_n), .tach_s(tach_s), .rps(rps_q), .gate_end(gate_end));
endmodule

// File: rtl/fan_i2c_ctrl_chk.sv
module fan_i2c_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_low,
    input logic       fan_en,
    input logic       pwm,
    input logic [7:0] duty,
    input logic       gate_end,
    input logic [7:0] rps
);
    // R4: enable clear in the previous cycle keeps the drive low
    p_pwm_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fan_en) |-> !pwm);

    // R5: stored duty never exceeds 100
    p_duty_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        duty <= 8'd100);

    // R7: the rate register moves only when a window closes
    p_rps_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end |=> $stable(rps));

    // R10: SDA pull stays steady while SCL is high
    p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_low));
endmodule

bind fan_i2c_ctrl fan_i2c_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_low(sda_pull_low_o),
    .fan_en(fan_en), .pwm(pwm_o), .duty(duty_q), .gate_end(gate_end), .rps(rps_q));

// File: tb/fan_i2c_ctrl_tb.sv
module fan_i2c_ctrl_tb;
    localparam int Q       = 20;
    localparam int TDIV    = 2;
    localparam int GATE    = 2000;
    localparam int PERIODC = 100 * TDIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic tach = 1'b0;
    logic sda_low, pwm;
    int   tach_half = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    wire  sda_bus = sda_m & ~sda_low;

    always #4 clk = ~clk;

    fan_i2c_ctrl #(.FILT_LEN(3), .TICK_DIV(TDIV), .GATE_CYCLES(GATE)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_low_o(sda_low), .tach_i(tach), .pwm_o(pwm));

    // stimulus: {ctrl, duty, expected high clocks per period}
    localparam logic [23:0] VEC [6] = '{
        {8'h80, 8'd50,  8'd100},
        {8'h80, 8'd100, 8'd200},
        {8'h80, 8'd0,   8'd0},
        {8'h80, 8'd150, 8'd200},
        {8'h00, 8'd50,  8'd0},
        {8'hFF, 8'd1,   8'd2}
    };

    initial begin
        forever begin
            if (tach_half == 0) begin
                tach = 1'b0;
                @(negedge clk);
            end else begin
                repeat (tach_half) @(negedge clk);
                tach = ~tach;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
    endtask

    task automatic i2c_bit(input logic b, output logic s);
        sda_m = b; qwait(); scl_m = 1'b1; qwait();
        s = sda_bus; qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic i2c_wr(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) i2c_bit(d[i], s);
        i2c_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic i2c_rd(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            i2c_bit(1'b1, s);
            d[i] = s;
        end
        i2c_bit(~give_ack, s);
    endtask

    task automatic reg_write(input logic [7:0] p, input logic [7:0] d0,
                             input logic [7:0] d1, input int n);
        logic a;
        i2c_start();
        i2c_wr(8'hE8, a);
        i2c_wr(p, a);
        i2c_wr(d0, a);
        if (n > 1) i2c_wr(d1, a);
        i2c_stop();
    endtask

    task automatic reg_read(input logic [7:0] p, input int n,
                            output logic [7:0] d0, output logic [7:0] d1);
        logic a;
        i2c_start();
        i2c_wr(8'hE8, a);
        i2c_wr(p, a);
        i2c_start();
        i2c_wr(8'hE9, a);
        i2c_rd(n > 1, d0);
        d1 = 8'h00;
        if (n > 1) i2c_rd(1'b0, d1);
        i2c_stop();
    endtask

    task automatic pwm_high(output int h);
        h = 0;
        repeat (PERIODC) begin
            @(negedge clk);
            h += int'(pwm);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r0, r1;
        logic       a;
        int         h;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        check("R4 pwm low after reset", int'(pwm), 0);
        check("R10 sda released after reset", int'(sda_low), 0);
        reg_read(8'd0, 1, r0, r1);
        check("R3 ctrl reset value", r0, 8'h00);

        // default duty 80 once enabled
        reg_write(8'd0, 8'h80, 8'h00, 1);
        pwm_high(h);
        check("R5 default duty 80", h, 80 * TDIV);

        // table: write ctrl and duty with auto-increment, read ctrl, measure PWM
        foreach (VEC[i]) begin
            reg_write(8'd0, VEC[i][23:16], VEC[i][15:8], 2);
            reg_read(8'd0, 1, r0, r1);
            check("R3 ctrl readback", r0, VEC[i][23:16]);
            pwm_high(h);
            check("R6 pwm high clocks (R2 R4 R5)", h, VEC[i][7:0]);
        end

        // wrong address: no ACK and no effect
        reg_write(8'd0, 8'h80, 8'd30, 2);
        i2c_start();
        i2c_wr(8'hEA, a);
        check("R1 foreign address nack", int'(a), 0);
        i2c_wr(8'h00, a);
        i2c_wr(8'h00, a);
        i2c_stop();
        reg_read(8'd0, 1, r0, r1);
        check("R1 ctrl untouched by foreign address", r0, 8'h80);
        i2c_start();
        i2c_wr(8'hE8, a);
        i2c_stop();
        check("R1 own address ack", int'(a), 1);

        // unmapped pointer: write ignored, read zero
        reg_write(8'd1, 8'd40, 8'h55, 2);
        pwm_high(h);
        check("R8 duty kept after write spill to pointer 2", h, 40 * TDIV);
        reg_write(8'd5, 8'h00, 8'h00, 1);
        reg_read(8'd0, 1, r0, r1);
        check("R8 ctrl untouched by pointer 5 write", r0, 8'h80);
        reg_read(8'd5, 1, r0, r1);
        check("R8 unmapped reads zero", r0, 8'h00);

        // tachometer: 20 edges per window
        tach_half = 50;
        repeat (2 * GATE + 500) @(negedge clk);
        reg_read(8'd1, 1, r0, r1);
        check("R7 rate 20 per window", r0, 20);
        reg_read(8'd0, 2, r0, r1);
        check("R9 repeated-start read byte 0 ctrl", r0, 8'h80);
        check("R2 auto-increment read byte 1 rate", r1, 20);

        // saturation
        tach_half = 2;
        repeat (2 * GATE + 500) @(negedge clk);
        reg_read(8'd1, 1, r0, r1);
        check("R7 rate saturates at 255", r0, 255);

        // stop the fan signal
        tach_half = 0;
        repeat (2 * GATE + 500) @(negedge clk);
        reg_read(8'd1, 1, r0, r1);
        check("R7 rate zero with no edges", r0, 0);
        check("R10 sda released when idle", int'(sda_low), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule